// File: doc/BRIEF.md
# Bus-Stuffing Instruction Sequencer

This block sits behind a cartridge slot of a 6502-family console and turns a list of high-level commands into the instruction bytes the CPU fetches from cartridge space. Each command becomes exactly one instruction: an opcode followed by its operand bytes. For a command that writes a video-chip register, the block also overrides the data bus during the CPU's own store cycle. It does this by pulling individual data lines low. The CPU accumulator is assumed to hold $FF, so any value can be forced onto the bus that way. The address bus is never driven.

A host fills two command banks. The sequencer executes one bank while the host refills the other. After a programmable number of CPU cycles (one scanline), the sequencer switches banks at the next instruction boundary, invalidates the bank it left and raises a one-clock interrupt. If the active bank runs out of valid commands, the block feeds NOPs so the CPU never fetches undefined bytes. Read commands capture the value the CPU reads into a small ring of results. When the ring is full, a new capture overwrites the oldest entry. The host can clear the ring.

Each CPU bus cycle is marked by a one-clock `cpu_done_i` strobe at its end. The cartridge-select (A12) and read/write lines stay valid for the whole cycle.

Top module: `bstuff_seq`

## Requirements
- R1: After reset, the bus and stuffing enables are 0, `irq_o` is 0, bank 0 is active and the result count is 0.
- R2: On an opcode or operand fetch, `bus_oe_o` is 1 and `bus_data_o` carries the byte only while `cpu_a12_i` and `cpu_rw_i` are both 1. Otherwise both are 0. The byte sequences are as follows:
  - NOP kind 0: EA, EA.
  - Zero-page write kind 1: 85, addr, then a write cycle.
  - Absolute write kind 2: 8D, addr, 00, then a write cycle.
  - Double write kind 3: 46, addr, then a quiet read, then two write cycles.
  - Jump kind 4: 4C, 00, 10.
  - Zero-page read kind 5: A5, addr, then a capture cycle.
  - Absolute read kind 6: AD, addr, 00, then a capture cycle.
  - Kind 7: behaves as a NOP.
- R3: On a write cycle with `cpu_rw_i` at 0, `stuff_oe_o` equals the bitwise inverse of the value, so only the 0 bits are pulled low. `bus_oe_o` stays 0, and `stuff_oe_o` is 0 on every other cycle.
- R4: The double-write command stuffs its first value on the first write cycle and its second value on the second. Nothing is driven on its quiet read cycle.
- R5: An entry that was never written, or an index past the end of the bank, executes as a NOP.
- R6: Cycles are counted from the last swap. A swap happens when an instruction ends and the count has reached `LINE_CYCLES`. On a swap the active bank toggles, execution restarts at index 0, every entry of the bank just left is invalidated, and `irq_o` is high for exactly one clock.
- R7: A host write to the bank that is currently active is ignored.
- R8: On the final cycle of a read command with `cpu_rw_i` at 1, `cpu_data_i` is stored in the ring. The count saturates at `RES_DEPTH`. When the ring is full, the oldest entry is overwritten. `res_sel_i` = 0 selects the oldest entry.
- R9: `res_clr_i` empties the ring. A clear in the same clock as a capture leaves only the new value.
- R10: Command word layout: bits 26:24 are the kind, 23:16 the register address, 15:8 the first value, and 7:0 the second value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cpu_done_i | input | 1 | One-clock strobe at the end of a CPU bus cycle |
| cpu_a12_i | input | 1 | Cartridge-space select of the current cycle |
| cpu_rw_i | input | 1 | CPU read (1) / write (0) |
| cpu_data_i | input | 8 | Snooped data bus |
| bus_oe_o | output | 1 | Drive enable for fetched bytes |
| bus_data_o | output | 8 | Fetched byte |
| stuff_oe_o | output | 8 | Per-bit pull-low enables |
| host_we_i | input | 1 | Host command write strobe |
| host_bank_i | input | 1 | Target bank of the host write |
| host_idx_i | input | $clog2(DEPTH) | Entry index of the host write |
| host_cmd_i | input | 27 | Command word (R10 layout) |
| irq_o | output | 1 | One-clock swap interrupt |
| active_bank_o | output | 1 | Bank currently executing |
| res_clr_i | input | 1 | Empty the result ring |
| res_sel_i | input | $clog2(RES_DEPTH) | Result index, 0 = oldest |
| res_data_o | output | 8 | Selected result |
| res_count_o | output | $clog2(RES_DEPTH+1) | Number of stored results |

## Verification
The interesting collision is the last cycle of a read command that also closes the scanline. In that one clock the ring stores a value while the banks swap, the old bank is invalidated and the interrupt rises. The bench builds every bank so that a zero-page read ends the line, and in one round it also asserts the clear on that same strobe. A behavioural reference updates its result queue, bank flags and pending-interrupt flag in that same step. The outputs, ring contents and count are then compared against it on every clock.

// File: rtl/bstuff_pkg.sv
package bstuff_pkg;

    localparam int CMD_W = 27;

    localparam logic [7:0] OP_NOP = 8'hEA;
    localparam logic [7:0] OP_STZ = 8'h85;
    localparam logic [7:0] OP_STA = 8'h8D;
    localparam logic [7:0] OP_LDZ = 8'hA5;
    localparam logic [7:0] OP_LDA = 8'hAD;
    localparam logic [7:0] OP_LSZ = 8'h46;
    localparam logic [7:0] OP_JMP = 8'h4C;

    typedef enum logic [2:0] {
        CK_NOP = 3'd0, CK_WR3 = 3'd1, CK_WR4 = 3'd2, CK_RMW = 3'd3,
        CK_JMP = 3'd4, CK_RD3 = 3'd5, CK_RD4 = 3'd6, CK_RSV = 3'd7
    } cmd_kind_e;

    typedef enum logic [1:0] {SK_FETCH, SK_WRITE, SK_CAPT, SK_QUIET} step_kind_e;

    // R10: kind / register address / first value / second value
    typedef struct packed {
        cmd_kind_e  kind;
        logic [7:0] reg_addr;
        logic [7:0] val_a;
        logic [7:0] val_b;
    } cmd_t;

    typedef struct packed {
        step_kind_e sk;
        logic [7:0] data;
        logic       last;
    } step_t;

    function automatic step_t decode_step(cmd_t c, logic [2:0] s);
        step_t r;
        r.sk   = SK_FETCH;
        r.data = OP_NOP;
        r.last = 1'b0;
        case (c.kind)
            CK_WR3: case (s)
                3'd0: r.data = OP_STZ;
                3'd1: r.data = c.reg_addr;
                default: begin r.sk = SK_WRITE; r.data = c.val_a; r.last = 1'b1; end
            endcase
            CK_WR4: case (s)
                3'd0: r.data = OP_STA;
                3'd1: r.data = c.reg_addr;
                3'd2: r.data = 8'h00;
                default: begin r.sk = SK_WRITE; r.data = c.val_a; r.last = 1'b1; end
            endcase
            CK_RMW: case (s)
                3'd0: r.data = OP_LSZ;
                3'd1: r.data = c.reg_addr;
                3'd2: begin r.sk = SK_QUIET; r.data = 8'h00; end
                3'd3: begin r.sk = SK_WRITE; r.data = c.val_a; end
                default: begin r.sk = SK_WRITE; r.data = c.val_b; r.last = 1'b1; end
            endcase
            CK_JMP: case (s)
                3'd0: r.data = OP_JMP;
                3'd1: r.data = 8'h00;
                default: begin r.data = 8'h10; r.last = 1'b1; end
            endcase
            CK_RD3: case (s)
                3'd0: r.data = OP_LDZ;
                3'd1: r.data = c.reg_addr;
                default: begin r.sk = SK_CAPT; r.data = 8'h00; r.last = 1'b1; end
            endcase
            CK_RD4: case (s)
                3'd0: r.data = OP_LDA;
                3'd1: r.data = c.reg_addr;
                3'd2: r.data = 8'h00;
                default: begin r.sk = SK_CAPT; r.data = 8'h00; r.last = 1'b1; end
            endcase
            default: r.last = (s != 3'd0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bstuff_cmd_bank.sv
module bstuff_cmd_bank
    import bstuff_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     host_we_i,
    input  logic                     host_bank_i,
    input  logic [$clog2(DEPTH)-1:0] host_idx_i,
    input  logic [CMD_W-1:0]         host_cmd_i,
    input  logic                     active_i,
    input  logic                     swap_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output cmd_t                     rd_cmd_o,
    output logic                     rd_valid_o
);

    typedef struct packed {
        logic [1:0][DEPTH-1:0] vld;
        cmd_t [1:0][DEPTH-1:0] cmd;
    } bank_t;

    bank_t b_d, b_q;
    logic  wr_ok;

    always_comb begin
        b_d   = b_q;
        wr_ok = host_we_i && (host_bank_i != active_i);
        if (swap_i) b_d.vld[active_i] = '0;
        if (wr_ok) begin
            b_d.cmd[host_bank_i][host_idx_i] = cmd_t'(host_cmd_i);
            b_d.vld[host_bank_i][host_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) b_q <= '0;
        else         b_q <= b_d;
    end

    assign rd_cmd_o   = b_q.cmd[active_i][rd_idx_i];
    assign rd_valid_o = b_q.vld[active_i][rd_idx_i];

    // R7: a write aimed at the running bank leaves all stored commands untouched
    assert_ignore_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_we_i && host_bank_i == active_i) |=> (b_q.cmd == $past(b_q.cmd)));

    // R6: the bank that was left holds no valid entry afterwards
    assert_left_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swap_i && !(host_we_i && host_bank_i == active_i)) |=> (b_q.vld[$past(active_i)] == '0));

endmodule

// File: rtl/bstuff_result_ring.sv
module bstuff_result_ring #(
    parameter int RES_DEPTH = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             push_i,
    input  logic [7:0]                       push_data_i,
    input  logic                             clr_i,
    input  logic [$clog2(RES_DEPTH)-1:0]     sel_i,
    output logic [7:0]                       data_o,
    output logic [$clog2(RES_DEPTH+1)-1:0]   count_o
);

    localparam int RW = $clog2(RES_DEPTH);
    localparam int CW = $clog2(RES_DEPTH+1);

    typedef struct packed {
        logic [RES_DEPTH-1:0][7:0] mem;
        logic [RW-1:0]             wptr;
        logic [CW-1:0]             cnt;
    } ring_t;

    ring_t       r_d, r_q;
    logic [RW-1:0] slot;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.wptr = '0;
            r_d.cnt  = '0;
        end
        if (push_i) begin
            r_d.mem[r_d.wptr] = push_data_i;
            r_d.wptr = (r_d.wptr == RW'(RES_DEPTH-1)) ? '0 : r_d.wptr + 1'b1;
            if (r_d.cnt != CW'(RES_DEPTH)) r_d.cnt = r_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        slot = RW'((32'(r_q.wptr) + 32'(RES_DEPTH) - 32'(r_q.cnt) + 32'(sel_i)) % 32'(RES_DEPTH));
    end

    assign data_o  = r_q.mem[slot];
    assign count_o = r_q.cnt;

    assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CW'(RES_DEPTH));

    assert_clear_keeps_new_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && push_i) |=> (count_o == CW'(1) && data_o == $past(push_data_i)) || (sel_i != '0));

    assert_clear_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !push_i) |=> (count_o == '0));

endmodule

// File: rtl/bstuff_seq.sv
module bstuff_seq
    import bstuff_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int RES_DEPTH   = 8,
    parameter int LINE_CYCLES = 76
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           cpu_done_i,
    input  logic                           cpu_a12_i,
    input  logic                           cpu_rw_i,
    input  logic [7:0]                     cpu_data_i,
    output logic                           bus_oe_o,
    output logic [7:0]                     bus_data_o,
    output logic [7:0]                     stuff_oe_o,
    input  logic                           host_we_i,
    input  logic                           host_bank_i,
    input  logic [$clog2(DEPTH)-1:0]       host_idx_i,
    input  logic [CMD_W-1:0]               host_cmd_i,
    output logic                           irq_o,
    output logic                           active_bank_o,
    input  logic                           res_clr_i,
    input  logic [$clog2(RES_DEPTH)-1:0]   res_sel_i,
    output logic [7:0]                     res_data_o,
    output logic [$clog2(RES_DEPTH+1)-1:0] res_count_o
);

    localparam int IW = $clog2(DEPTH);
    localparam int XW = $clog2(DEPTH+1);
    localparam int LW = $clog2(LINE_CYCLES+1);

    typedef struct packed {
        logic          bank;
        logic [XW-1:0] idx;
        logic [2:0]    step;
        logic [LW-1:0] line;
        logic          irq;
    } seq_t;

    seq_t          s_d, s_q;
    cmd_t          rd_cmd, cur;
    logic          rd_valid, in_range, swap, capture;
    step_t         st;
    logic [LW-1:0] line_inc;

    bstuff_cmd_bank #(.DEPTH(DEPTH)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_we_i  (host_we_i),
        .host_bank_i(host_bank_i),
        .host_idx_i (host_idx_i),
        .host_cmd_i (host_cmd_i),
        .active_i   (s_q.bank),
        .swap_i     (swap),
        .rd_idx_i   (s_q.idx[IW-1:0]),
        .rd_cmd_o   (rd_cmd),
        .rd_valid_o (rd_valid)
    );

    bstuff_result_ring #(.RES_DEPTH(RES_DEPTH)) u_ring (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (capture),
        .push_data_i(cpu_data_i),
        .clr_i      (res_clr_i),
        .sel_i      (res_sel_i),
        .data_o     (res_data_o),
        .count_o    (res_count_o)
    );

    always_comb begin
        in_range   = (s_q.idx < XW'(DEPTH));
        cur        = (in_range && rd_valid) ? rd_cmd : '0;
        st         = decode_step(cur, s_q.step);
        bus_oe_o   = (st.sk == SK_FETCH) && cpu_a12_i && cpu_rw_i;
        bus_data_o = bus_oe_o ? st.data : 8'h00;
        stuff_oe_o = (st.sk == SK_WRITE && !cpu_rw_i) ? ~st.data : 8'h00;
        capture    = cpu_done_i && (st.sk == SK_CAPT) && cpu_rw_i;
        line_inc   = (s_q.line >= LW'(LINE_CYCLES)) ? s_q.line : s_q.line + 1'b1;
        swap       = cpu_done_i && st.last && (line_inc >= LW'(LINE_CYCLES));

        s_d     = s_q;
        s_d.irq = swap;
        if (cpu_done_i) begin
            s_d.line = line_inc;
            if (st.last) begin
                s_d.step = '0;
                if (swap) begin
                    s_d.bank = ~s_q.bank;
                    s_d.idx  = '0;
                    s_d.line = '0;
                end else if (in_range) begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign irq_o         = s_q.irq;
    assign active_bank_o = s_q.bank;

    assert_drive_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> (cpu_a12_i && cpu_rw_i));

    assert_no_contention_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stuff_oe_o != 8'h00) |-> (!cpu_rw_i && !bus_oe_o));

    assert_irq_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    assert_bank_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (active_bank_o != $past(active_bank_o)));

endmodule

// File: tb/bstuff_seq_tb.sv
module bstuff_seq_tb_top;

    localparam int DEPTH = 8;
    localparam int RD    = 4;
    localparam int LINE  = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_done = 0, cpu_a12 = 0, cpu_rw = 1;
    logic [7:0] cpu_data = 0;
    logic bus_oe; logic [7:0] bus_data, stuff_oe;
    logic host_we = 0, host_bank = 0;
    logic [2:0] host_idx = 0;
    logic [26:0] host_cmd = 0;
    logic irq, active;
    logic res_clr = 0;
    logic [1:0] res_sel = 0;
    logic [7:0] res_data;
    logic [2:0] res_count;

    int checks = 0, fails = 0;

    // reference model state
    int  cmds [2][DEPTH];
    bit  vld  [2][DEPTH];
    int  m_bank = 0, m_idx = 0, m_step = 0, m_line = 0;
    bit  irq_pend = 0;
    int  rq[$];
    bit  ign_on = 0;
    bit  clr_arm = 0;

    always #10 clk = ~clk;

    bstuff_seq #(.DEPTH(DEPTH), .RES_DEPTH(RD), .LINE_CYCLES(LINE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cpu_done_i(cpu_done), .cpu_a12_i(cpu_a12),
        .cpu_rw_i(cpu_rw), .cpu_data_i(cpu_data), .bus_oe_o(bus_oe), .bus_data_o(bus_data),
        .stuff_oe_o(stuff_oe), .host_we_i(host_we), .host_bank_i(host_bank),
        .host_idx_i(host_idx), .host_cmd_i(host_cmd), .irq_o(irq), .active_bank_o(active),
        .res_clr_i(res_clr), .res_sel_i(res_sel), .res_data_o(res_data), .res_count_o(res_count)
    );

    // R10: kind in 26:24, address 23:16, first value 15:8, second value 7:0
    function automatic int mk(int k, int a, int va, int vb);
        return (k << 24) | (a << 16) | (va << 8) | vb;
    endfunction

    // sk: 0 fetch, 1 write, 2 capture, 3 quiet
    function automatic void exp_step(input int c, input int s, output int sk, output int byt, output bit last);
        int k, a, va, vb;
        k = (c >> 24) & 7; a = (c >> 16) & 255; va = (c >> 8) & 255; vb = c & 255;
        sk = 0; byt = 'hEA; last = 0;
        case (k)
            1: begin if (s == 0) byt = 'h85; else if (s == 1) byt = a; else begin sk = 1; byt = va; last = 1; end end
            2: begin if (s == 0) byt = 'h8D; else if (s == 1) byt = a; else if (s == 2) byt = 0;
                     else begin sk = 1; byt = va; last = 1; end end
            3: begin if (s == 0) byt = 'h46; else if (s == 1) byt = a; else if (s == 2) begin sk = 3; byt = 0; end
                     else if (s == 3) begin sk = 1; byt = va; end else begin sk = 1; byt = vb; last = 1; end end
            4: begin if (s == 0) byt = 'h4C; else if (s == 1) byt = 0; else begin byt = 'h10; last = 1; end end
            5: begin if (s == 0) byt = 'hA5; else if (s == 1) byt = a; else begin sk = 2; byt = 0; last = 1; end end
            6: begin if (s == 0) byt = 'hAD; else if (s == 1) byt = a; else if (s == 2) byt = 0;
                     else begin sk = 2; byt = 0; last = 1; end end
            default: last = (s != 0);
        endcase
    endfunction

    function automatic int cur_cmd();
        if (m_idx < DEPTH && vld[m_bank][m_idx]) return cmds[m_bank][m_idx];
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int sk, byt, eo, ed, es, c; bit last; string tag;
        c = cur_cmd();
        exp_step(c, m_step, sk, byt, last);
        eo = (sk == 0 && cpu_a12 && cpu_rw) ? 1 : 0;
        ed = eo ? byt : 0;
        es = (sk == 1 && !cpu_rw) ? (~byt) & 255 : 0;
        tag = "R2";
        if (((c >> 24) & 7) == 3) tag = "R4";
        else if (c == 0) tag = "R5";
        if (ign_on && m_bank == 0 && m_idx == 7) tag = "R7";
        check({tag, " bus_oe"}, bus_oe, eo);
        check({tag, " bus_data"}, bus_data, ed);
        check((tag == "R2") ? "R3 stuff" : {tag, " stuff"}, stuff_oe, es);
        check("R6 irq", irq, irq_pend);
        irq_pend = 0;
        check("R6 active bank", active, m_bank);
    endtask

    task automatic model_done(int din, bit rwv, bit clr);
        int sk, byt; bit last;
        exp_step(cur_cmd(), m_step, sk, byt, last);
        if (clr) rq.delete();
        if (sk == 2 && rwv) begin
            rq.push_back(din);
            if (rq.size() > RD) void'(rq.pop_front());
        end
        if (m_line < LINE) m_line++;
        if (last) begin
            m_step = 0;
            if (m_line >= LINE) begin
                for (int i = 0; i < DEPTH; i++) vld[m_bank][i] = 0;
                m_bank ^= 1; m_idx = 0; m_line = 0; irq_pend = 1;
            end else if (m_idx < DEPTH) m_idx++;
        end else m_step++;
    endtask

    task automatic cpu_cycle(bit a12v, bit rwv, int din, bit clr);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cpu_a12 = a12v; cpu_rw = rwv; cpu_data = din[7:0];
            cpu_done = (k == 3); res_clr = (k == 3) && clr;
            #1 check_all();
        end
        @(posedge clk); #1;
        model_done(din, rwv, clr);
        cpu_done = 0; res_clr = 0;
    endtask

    task automatic cpu_step(bit force_off);
        int sk, byt; bit last, a12v, rwv, clr;
        exp_step(cur_cmd(), m_step, sk, byt, last);
        a12v = (sk == 0) && !force_off;
        rwv  = (sk != 1);
        clr  = clr_arm && sk == 2 && m_idx == 6;   // R9 clear on the capture that closes the line
        if (clr) clr_arm = 0;
        cpu_cycle(a12v, rwv, int'($urandom_range(255)), clr);
    endtask

    task automatic host_write(bit b, int i, int c);
        @(negedge clk);
        host_we = 1; host_bank = b; host_idx = i[2:0]; host_cmd = c[26:0];
        #1 check_all();
        @(posedge clk); #1;
        if (b != m_bank) begin cmds[b][i] = c; vld[b][i] = 1; end
        host_we = 0;
    endtask

    task automatic check_ring();
        @(negedge clk); #1 check_all();
        check("R8 count", res_count, rq.size());
        for (int i = 0; i < rq.size(); i++) begin
            @(negedge clk); res_sel = i[1:0];
            #1 check_all();
            check("R8 R9 entry", res_data, rq[i]);
        end
    endtask

    task automatic run_until_bank(int b);
        while (m_bank != b) cpu_step(0);
    endtask

    initial begin
        for (int b = 0; b < 2; b++) for (int i = 0; i < DEPTH; i++) begin cmds[b][i] = 0; vld[b][i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 bus_oe", bus_oe, 0); check("R1 stuff", stuff_oe, 0);
        check("R1 irq", irq, 0); check("R1 active", active, 0); check("R1 count", res_count, 0);
        rst_n = 1;
        repeat (3) cpu_step(0);
        cpu_step(1);                        // R2: fetch outside cartridge space is not driven
        // R7: write into the running bank 0, entry 7 is reached later in this line as filler
        ign_on = 1;
        host_write(0, 7, mk(1, 'h09, 'h11, 0));
        for (int r = 0; r < 5; r++) begin
            int b;
            b = m_bank ^ 1;
            host_write(b, 0, mk(2, 'h06, 'h30 + r, 0));
            host_write(b, 1, mk(3, 'h09, 'hC3 ^ r, 'h3C + r));
            host_write(b, 2, mk(5, 'h30 + r, 0, 0));
            host_write(b, 3, mk(1, 'h1B, 'h5A - r, 0));
            host_write(b, 4, mk(6, 'h31, 0, 0));
            host_write(b, 5, mk(4, 0, 0, 0));
            host_write(b, 6, mk(5, 'h32, 0, 0));
            host_write(b, 7, mk(7, 0, 0, 0));
            clr_arm = (r == 3);
            run_until_bank(b);
            ign_on = 0;
            check_ring();
        end
        run_until_bank(m_bank ^ 1);
        check_ring();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule